// File: doc/BRIEF.md
# D-Channel Access Priority Controller

This block lets one terminal on a shared point-to-multipoint bus win the signalling D-channel. On every D-bit slot it watches the echo bit that the network side returns. It counts unbroken runs of echoed ones. Once the run reaches an access threshold while a request is pending, the block begins the packet by sending an opening flag.

The threshold has two parts. The first is a class chosen by the user. The second is an internal level that adjusts itself. After a successful send the internal level falls. It recovers only after a longer run of ones has been seen. While transmitting, the block compares each driven bit with its echo. A driven one that comes back as zero means another terminal has won the bus. The block then releases the line at once and flags the collision. It keeps the acknowledge until the next frame strobe and then returns to counting.

Packet body framing and line coding are outside the block. The body arrives bit by bit on `tx_bit`. The framer marks the end of a packet with `pkt_done`.

Top module: `dch_access_ctrl`

## Requirements
- R1: In the counting state, each `bit_stb` with `echo_bit`=1 adds one to a saturating run counter, and each `bit_stb` with `echo_bit`=0 clears it to zero.
- R2: `prio_low`=0 selects the high class with thresholds 8 or 9; `prio_low`=1 selects the low class with thresholds 10 or 11.
- R3: When the internal level is high, the lower threshold of the class applies (8 or 10). When it is low, the higher threshold applies (9 or 11).
- R4: On the `bit_stb` at which the run count reaches the threshold with `req`=1, `d_out` starts the flag 01111110, leftmost bit first, one bit per strobe.
- R5: While no access is in progress, `d_out` is held at 1.
- R6: `ack` goes high on the strobe that ends the first (zero) bit of the opening flag, and stays low before it.
- R7: If `d_out`=1 and `echo_bit`=0 on a strobe during the flag or the body, `coll_pulse` is high for exactly one cycle. In that same cycle `d_out` returns to 1 and counting restarts from zero.
- R8: After a collision, `ack` stays high until the next `frame_stb` and falls on that cycle.
- R9: `pkt_done` during the body ends the access: `ack` and the internal level go low and `d_out` returns to 1. The level goes high again only when a run reaches the class's higher threshold (9 or 11).
- R10: After reset, `d_out`=1, `ack`=0, `coll_pulse`=0, the internal level is high and the run count is zero.
- R11: After the last flag bit, each strobe puts the current `tx_bit` on `d_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe per D/E bit slot |
| frame_stb | input | 1 | One-cycle frame strobe |
| echo_bit | input | 1 | Echo bit returned for the current slot |
| req | input | 1 | Access request |
| prio_low | input | 1 | User class: 0 high (8/9), 1 low (10/11) |
| tx_bit | input | 1 | Packet body bit stream |
| pkt_done | input | 1 | Pulse: packet completed successfully |
| d_out | output | 1 | D bit to drive in the current slot |
| ack | output | 1 | Channel acquired |
| coll_pulse | output | 1 | One-cycle collision indication |

## Verification
On every cycle, the assertions check the following: the counter steps and clears with the echo, the level falls after a completed packet and rises after a recovery run, the collision pulse lasts one cycle and always comes with a released line, the acknowledge rises only after a driven zero, and the line idles at one. The scenarios measure how many ones each class and level needs before access. Only they can show that the level changes between runs: an eight-one run leaves it low, and a nine-one run raises it. They also show that the acknowledge survives a collision until the frame strobe, and that counting restarts afterwards.

// File: rtl/dca_pkg.sv
package dca_pkg;
   typedef enum logic [1:0] {
      ST_COUNT = 2'd0,
      ST_FLAG  = 2'd1,
      ST_BODY  = 2'd2
   } acc_state_e;

   function automatic int unsigned access_thr(input bit cls_low, input bit lvl_hi,
                                              input int unsigned hi_base,
                                              input int unsigned lo_base,
                                              input int unsigned step);
      int unsigned base;
      base = cls_low ? lo_base : hi_base;
      return lvl_hi ? base : base + step;
   endfunction
endpackage

// File: rtl/dca_echo_cnt.sv
module dca_echo_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             counting,
   input  logic             stb,
   input  logic             echo,
   input  logic [CNT_W-1:0] thr_acc,
   input  logic [CNT_W-1:0] thr_rec,
   output logic             reach_acc,
   output logic             reach_rec
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] run_inc;
   logic             one_seen;

   assign run_inc   = (run_cnt == CNT_MAX) ? run_cnt : run_cnt + 1'b1;
   assign one_seen  = counting && stb && echo;
   assign reach_acc = one_seen && (run_inc >= thr_acc);
   assign reach_rec = one_seen && (run_inc >= thr_rec);

   always_ff @(posedge clk) begin
      if (!rst_n)             run_cnt <= '0;
      else if (!counting)     run_cnt <= '0;
      else if (stb)           run_cnt <= echo ? run_inc : '0;
   end

   p_cnt_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && stb && !echo) |=> (run_cnt == '0));
   p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && stb && echo && run_cnt != CNT_MAX) |=> (run_cnt == $past(run_cnt) + 1'b1));
endmodule

// File: rtl/dca_prio_level.sv
module dca_prio_level #(
   parameter int HI_BASE  = 8,
   parameter int LO_BASE  = 10,
   parameter int LVL_STEP = 1,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cls_low,
   input  logic             pkt_ok,
   input  logic             reach_rec,
   output logic             lvl_hi,
   output logic [CNT_W-1:0] thr_acc,
   output logic [CNT_W-1:0] thr_rec
);
   import dca_pkg::*;

   localparam logic [CNT_W-1:0] HI_REC = CNT_W'(HI_BASE + LVL_STEP);
   localparam logic [CNT_W-1:0] LO_REC = CNT_W'(LO_BASE + LVL_STEP);

   assign thr_acc = CNT_W'(access_thr(cls_low, lvl_hi, HI_BASE, LO_BASE, LVL_STEP));
   assign thr_rec = cls_low ? LO_REC : HI_REC;

   always_ff @(posedge clk) begin
      if (!rst_n)          lvl_hi <= 1'b1;
      else if (pkt_ok)     lvl_hi <= 1'b0;
      else if (reach_rec)  lvl_hi <= 1'b1;
   end

   p_lvl_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ok |=> !lvl_hi);
   p_lvl_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reach_rec && !pkt_ok) |=> lvl_hi);
endmodule

// File: rtl/dca_tx_seq.sv
module dca_tx_seq #(
   parameter int              FLAG_LEN       = 8,
   parameter logic [FLAG_LEN-1:0] FLAG_PAT   = 8'h7E,
   parameter bit              FLAG_MSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic frame_stb,
   input  logic echo,
   input  logic req,
   input  logic tx_bit,
   input  logic pkt_done,
   input  logic reach_acc,
   output logic counting,
   output logic pkt_ok,
   output logic d_out,
   output logic ack,
   output logic coll_pulse
);
   import dca_pkg::*;

   localparam int FI_W = (FLAG_LEN > 1) ? $clog2(FLAG_LEN) : 1;
   localparam logic [FI_W-1:0] FI_LAST = FI_W'(FLAG_LEN - 1);

   acc_state_e      state;
   logic [FI_W-1:0] fi;
   logic [FI_W-1:0] fi_nxt;
   logic            drop_pend;
   logic            collided;
   logic [FLAG_LEN-1:0] flag_seq;

   // Flag bits rearranged so that flag_seq[0] is sent first.
   for (genvar i = 0; i < FLAG_LEN; i++) begin : g_flag
      if (FLAG_MSB_FIRST) begin : g_msb
         assign flag_seq[i] = FLAG_PAT[FLAG_LEN-1-i];
      end else begin : g_lsb
         assign flag_seq[i] = FLAG_PAT[i];
      end
   end

   assign fi_nxt   = (fi == FI_LAST) ? '0 : fi + 1'b1;
   assign counting = (state == ST_COUNT);
   assign collided = stb && d_out && !echo && (state != ST_COUNT);
   assign pkt_ok   = (state == ST_BODY) && pkt_done && !collided;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_COUNT;
         fi         <= '0;
         d_out      <= 1'b1;
         ack        <= 1'b0;
         coll_pulse <= 1'b0;
         drop_pend  <= 1'b0;
      end else begin
         coll_pulse <= 1'b0;
         if (frame_stb && drop_pend) begin
            ack       <= 1'b0;
            drop_pend <= 1'b0;
         end
         case (state)
            ST_COUNT: begin
               d_out <= 1'b1;
               if (reach_acc && req) begin
                  state     <= ST_FLAG;
                  fi        <= '0;
                  d_out     <= flag_seq[0];
                  drop_pend <= 1'b0;
               end
            end
            ST_FLAG: begin
               if (collided) begin
                  coll_pulse <= 1'b1;
                  d_out      <= 1'b1;
                  state      <= ST_COUNT;
                  drop_pend  <= 1'b1;
               end else if (stb) begin
                  if (fi == '0) ack <= 1'b1;
                  if (fi == FI_LAST) begin
                     state <= ST_BODY;
                     d_out <= tx_bit;
                  end else begin
                     fi    <= fi_nxt;
                     d_out <= flag_seq[fi_nxt];
                  end
               end
            end
            ST_BODY: begin
               if (collided) begin
                  coll_pulse <= 1'b1;
                  d_out      <= 1'b1;
                  state      <= ST_COUNT;
                  drop_pend  <= 1'b1;
               end else if (pkt_done) begin
                  state <= ST_COUNT;
                  d_out <= 1'b1;
                  ack   <= 1'b0;
               end else if (stb) begin
                  d_out <= tx_bit;
               end
            end
            default: begin
               state <= ST_COUNT;
               d_out <= 1'b1;
            end
         endcase
      end
   end

   p_coll_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      coll_pulse |=> !coll_pulse);
   p_coll_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      coll_pulse |-> (d_out && state == ST_COUNT));
   p_ack_after_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> ($past(stb) && !$past(d_out)));
   p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && drop_pend) |=> !ack);
   p_idle_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_COUNT && $past(state == ST_COUNT)) |-> d_out);
endmodule

// File: rtl/dch_access_ctrl.sv
module dch_access_ctrl #(
   parameter int HI_BASE        = 8,
   parameter int LO_BASE        = 10,
   parameter int LVL_STEP       = 1,
   parameter int FLAG_LEN       = 8,
   parameter logic [FLAG_LEN-1:0] FLAG_PAT = 8'h7E,
   parameter bit FLAG_MSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic frame_stb,
   input  logic echo_bit,
   input  logic req,
   input  logic prio_low,
   input  logic tx_bit,
   input  logic pkt_done,
   output logic d_out,
   output logic ack,
   output logic coll_pulse
);
   localparam int CNT_W = $clog2(LO_BASE + LVL_STEP + 1);
   localparam bit FIRST_FLAG_BIT = FLAG_MSB_FIRST ? FLAG_PAT[FLAG_LEN-1] : FLAG_PAT[0];

   if (HI_BASE < 1 || LVL_STEP < 1) begin : g_bad_base
      $error("thresholds and level step must be positive");
   end
   if (HI_BASE + LVL_STEP >= LO_BASE) begin : g_bad_order
      $error("high-class thresholds must lie below the low-class ones");
   end
   if (FLAG_LEN < 2) begin : g_bad_flag_len
      $error("flag must be at least two bits");
   end
   if (FIRST_FLAG_BIT != 1'b0) begin : g_bad_flag_lead
      $error("flag must open with a zero bit");
   end

   logic             counting;
   logic             pkt_ok;
   logic             reach_acc;
   logic             reach_rec;
   logic             lvl_hi;
   logic [CNT_W-1:0] thr_acc;
   logic [CNT_W-1:0] thr_rec;

   dca_prio_level #(
      .HI_BASE(HI_BASE), .LO_BASE(LO_BASE), .LVL_STEP(LVL_STEP), .CNT_W(CNT_W)
   ) u_level (
      .clk(clk), .rst_n(rst_n), .cls_low(prio_low), .pkt_ok(pkt_ok),
      .reach_rec(reach_rec), .lvl_hi(lvl_hi), .thr_acc(thr_acc), .thr_rec(thr_rec)
   );

   dca_echo_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .counting(counting), .stb(bit_stb), .echo(echo_bit),
      .thr_acc(thr_acc), .thr_rec(thr_rec), .reach_acc(reach_acc), .reach_rec(reach_rec)
   );

   dca_tx_seq #(
      .FLAG_LEN(FLAG_LEN), .FLAG_PAT(FLAG_PAT), .FLAG_MSB_FIRST(FLAG_MSB_FIRST)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .stb(bit_stb), .frame_stb(frame_stb), .echo(echo_bit),
      .req(req), .tx_bit(tx_bit), .pkt_done(pkt_done), .reach_acc(reach_acc),
      .counting(counting), .pkt_ok(pkt_ok), .d_out(d_out), .ack(ack),
      .coll_pulse(coll_pulse)
   );

   p_rst_level_r10: assert property (@(posedge clk)
      $past(!rst_n) |-> (lvl_hi && d_out && !ack && !coll_pulse));
endmodule

// File: tb/tb_dch_access_ctrl.sv
`timescale 1ns/1ps
module tb_dch_access_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_stb = 1'b0, frame_stb = 1'b0, echo_bit = 1'b1, req = 1'b0;
   logic prio_low = 1'b0, tx_bit = 1'b1, pkt_done = 1'b0;
   logic d_out, ack, coll_pulse;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dch_access_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frame_stb(frame_stb),
      .echo_bit(echo_bit), .req(req), .prio_low(prio_low), .tx_bit(tx_bit),
      .pkt_done(pkt_done), .d_out(d_out), .ack(ack), .coll_pulse(coll_pulse)
   );

   // Behavioural reference: phase 0 idle, 1 flag, 2 body.
   int  flag_bits[$] = '{0, 1, 1, 1, 1, 1, 1, 0};
   int  m_phase, m_run, m_pos;
   bit  m_lvl, m_d, m_ack, m_coll, m_hold;

   task automatic m_collide();
      m_coll = 1; m_d = 1; m_phase = 0; m_hold = 1; m_run = 0;
   endtask

   always @(posedge clk) begin
      int need, rec;
      if (!rst_n) begin
         m_phase = 0; m_run = 0; m_pos = 0; m_lvl = 1;
         m_d = 1; m_ack = 0; m_coll = 0; m_hold = 0;
      end else begin
         m_coll = 0;
         need = (prio_low ? 10 : 8) + (m_lvl ? 0 : 1);
         rec  = prio_low ? 11 : 9;
         if (frame_stb && m_hold) begin m_ack = 0; m_hold = 0; end
         if (m_phase == 0) begin
            m_d = 1;
            if (bit_stb) begin
               m_run = echo_bit ? ((m_run < 15) ? m_run + 1 : 15) : 0;
               if (echo_bit && m_run >= rec) m_lvl = 1;
               if (echo_bit && m_run >= need && req) begin
                  m_phase = 1; m_pos = 0; m_d = flag_bits[0]; m_hold = 0; m_run = 0;
               end
            end
         end else if (m_phase == 1) begin
            if (bit_stb && m_d && !echo_bit) m_collide();
            else if (bit_stb) begin
               if (m_pos == 0) m_ack = 1;
               if (m_pos == 7) begin m_phase = 2; m_d = tx_bit; end
               else begin m_pos++; m_d = flag_bits[m_pos]; end
            end
         end else begin
            if (bit_stb && m_d && !echo_bit) m_collide();
            else if (pkt_done) begin
               m_phase = 0; m_d = 1; m_ack = 0; m_lvl = 0; m_run = 0;
            end else if (bit_stb) m_d = tx_bit;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the reference.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(d_out == m_d, "R4/R11 d_out vs model", d_out, m_d);
         chk(ack == m_ack, "R6/R8 ack vs model", ack, m_ack);
         chk(coll_pulse == m_coll, "R7 coll_pulse vs model", coll_pulse, m_coll);
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 20000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
   end

   task automatic slot(input bit force_zero);
      bit_stb = 1'b1;
      echo_bit = force_zero ? 1'b0 : d_out;
      @(negedge clk);
      bit_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic measure(output int n);
      slot(1'b1);
      n = 0;
      for (int k = 0; k < 20; k++) begin
         slot(1'b0);
         n++;
         if (d_out == 1'b0) break;
      end
   endtask

   task automatic finish_packet(input string tag);
      int body[4] = '{1, 0, 0, 1};
      chk(ack == 1'b0, "R6 ack low before flag zero ends", ack, 0);
      for (int k = 1; k < 8; k++) begin
         slot(1'b0);
         chk(d_out == flag_bits[k], "R4 flag bit", d_out, flag_bits[k]);
         if (k == 1) chk(ack == 1'b1, "R6 ack after first zero", ack, 1);
      end
      for (int j = 0; j < 4; j++) begin
         tx_bit = body[j][0];
         slot(1'b0);
         chk(d_out == body[j][0], "R11 body bit follows tx_bit", d_out, body[j]);
      end
      req = 1'b0;
      pkt_done = 1'b1;
      @(negedge clk);
      pkt_done = 1'b0;
      tx_bit = 1'b1;
      chk(ack == 1'b0 && d_out == 1'b1, {tag, " R9 done releases"}, {ack, d_out}, 1);
   endtask

   task automatic run_access(input int exp_n, input string tag);
      int n;
      req = 1'b1;
      measure(n);
      chk(n == exp_n, tag, n, exp_n);
      finish_packet(tag);
   endtask

   task automatic ones_run(input int n);
      req = 1'b0;
      slot(1'b1);
      repeat (n) slot(1'b0);
      slot(1'b1);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(d_out == 1 && ack == 0 && coll_pulse == 0, "R10 reset outputs", {d_out, ack, coll_pulse}, 4);

      // R5: no request, long run of ones, line stays idle.
      for (int k = 0; k < 15; k++) begin
         slot(1'b0);
         chk(d_out == 1'b1, "R5 idle ones without request", d_out, 1);
      end

      prio_low = 1'b0;
      run_access(8, "R2 R3 high class high level needs 8");
      run_access(9, "R9 R3 level low after success needs 9");
      ones_run(8);
      run_access(9, "R9 run of 8 does not restore level");
      ones_run(9);
      run_access(8, "R9 run of 9 restores level");

      prio_low = 1'b1;
      run_access(11, "R2 low class low level needs 11");
      ones_run(11);
      run_access(10, "R2 R9 low class restored level needs 10");

      // Collision in the flag: high class, level low (needs 9, which restores level).
      prio_low = 1'b0;
      req = 1'b1;
      measure(n);
      chk(n == 9, "R1 R3 count before collision", n, 9);
      slot(1'b0);
      chk(ack == 1'b1, "R6 ack before collision", ack, 1);
      bit_stb = 1'b1; echo_bit = 1'b0;
      @(negedge clk);
      bit_stb = 1'b0;
      chk(coll_pulse == 1'b1 && d_out == 1'b1, "R7 collision pulse and release", {coll_pulse, d_out}, 3);
      @(negedge clk);
      chk(coll_pulse == 1'b0, "R7 pulse lasts one cycle", coll_pulse, 0);
      req = 1'b0;
      slot(1'b0);
      chk(ack == 1'b1, "R8 ack held until frame strobe", ack, 1);
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      chk(ack == 1'b0, "R8 ack drops at frame strobe", ack, 0);
      run_access(8, "R7 R1 counting restarts after collision");

      // R1: a zero in mid-run restarts the count.
      req = 1'b1;
      slot(1'b1);
      repeat (5) slot(1'b0);
      slot(1'b1);
      n = 0;
      for (int k = 0; k < 20; k++) begin
         slot(1'b0); n++;
         if (d_out == 1'b0) break;
      end
      chk(n == 9, "R1 zero echo clears run", n, 9);
      finish_packet("R1");

      repeat (4) @(negedge clk);
      summary();
   end
endmodule